// File: doc/BRIEF.md
# Manual Serial Pin Command Engine

This block lets software steer a serial slave one pin operation at a time, bypassing the automatic transfer engine. Each command word holds an opcode and, for shift operations, one data byte. The opcode chooses one of four actions: raise chip-select, lower chip-select, emit a single serial clock pulse, or shift a byte across one, two or four data lanes. With these primitives software can build any framing it needs. The main use is walking a slave through its reset sequence before normal framed traffic starts.

Commands take effect only while both the manual-enable input and the path-select input are high and the engine is idle. Clock and shift operations hold `busy` high until the last serial clock phase has ended. Shift operations with the write bit clear leave the data lanes undriven and collect the returned lane values into a read-data register. A valid flag marks new read data, and a separate clear strobe drops that flag.

Top module: `serial_pin_sequencer`

## Requirements
- R1: Out of reset: chip-select high, serial clock low, all data lanes zero and undriven, busy low, read data zero and read-valid low.
- R2: A command is accepted only on a clock where cmd_valid, man_en and path_sel are all 1 and busy is 0. If man_en or path_sel is 0, the command changes no output.
- R3: The opcode is in command bits 11:8. Value 0x0 drives chip-select high and 0x1 drives it low, one clock after acceptance, without raising busy. Any opcode not listed in R3 to R5 has no effect.
- R4: Opcode 0x2 produces one serial clock pulse: high for N system clocks, then low for N, where N is phase_len sampled at acceptance and a value of 0 counts as 1. Busy is high for exactly those 2N clocks and the serial clock is low whenever busy is low.
- R5: Opcodes 0x8, 0x9 and 0xA shift command bits 7:0 MSB first, 1, 2 or 4 bits per step, in 8, 4 or 2 steps. In each step the data is placed on the lanes for N clocks with the serial clock low, then held for N clocks with it high. Within a step, the lowest lane carries the least significant of the bits sent together. Chip-select does not change during the transfer.
- R6: Command bit 13 set marks a write: during the shift, the output enables of the lanes in use (lane 0 alone, lanes 1:0, or lanes 3:0) are high. With bit 13 clear, all enables stay low. All enables are low whenever busy is low.
- R7: On a read shift, the lanes in use on sdi are sampled on the last clock of each high phase and assembled MSB first. When busy falls, this byte appears on rdata and rdata_valid goes high.
- R8: A vld_clear pulse lowers rdata_valid on the next clock and leaves rdata unchanged.
- R9: A command presented while busy is high is ignored and does not disturb the transfer in progress.
- R10: The slave reset sequence (chip-select low, one single-lane shift, chip-select high, four single-lane shifts) produces 40 serial clock rising edges in total, 8 of them while chip-select is low, and ends with chip-select high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| man_en | input | 1 | Manual mode enable |
| path_sel | input | 1 | Routes the serial pins to this engine |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | CMD_W (16) | Command: bit 13 write, bits 11:8 opcode, bits 7:0 data |
| vld_clear | input | 1 | Clears the read-valid flag |
| phase_len | input | PHASE_W (8) | System clocks per serial clock phase |
| sdi | input | 4 | Serial data lanes from the slave |
| busy | output | 1 | Clock or shift operation in progress |
| csn | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock |
| sdo | output | 4 | Serial data lanes toward the slave |
| sdo_oe | output | 4 | Output enable of each data lane |
| rdata | output | DATA_W (8) | Byte collected by the last read shift |
| rdata_valid | output | 1 | rdata holds unread data |

## Verification
The hardest case to reach is a command that arrives while a transfer is running. It has to land inside a multi-clock shift, not at its edges. The bench drives a chip-select opcode on the first clock after a read shift has started. It then checks every later cycle of the transfer, and the chip-select level afterwards, against the undisturbed expectation. Read capture needs lane values that change per step exactly where the sampling edge falls. The bench therefore derives sdi from the step that its own expected pin timeline reports for the current cycle.

// File: rtl/serpin_pkg.sv
package serpin_pkg;

   localparam logic [3:0] OPC_CS_HIGH = 4'h0;
   localparam logic [3:0] OPC_CS_LOW  = 4'h1;
   localparam logic [3:0] OPC_PULSE   = 4'h2;
   localparam logic [3:0] OPC_SH_X1   = 4'h8;
   localparam logic [3:0] OPC_SH_X2   = 4'h9;
   localparam logic [3:0] OPC_SH_X4   = 4'hA;

   localparam int NUM_LANES = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PULSE_HI,
      ST_PULSE_LO,
      ST_SHIFT_LO,
      ST_SHIFT_HI
   } seq_state_e;

   typedef struct packed {
      logic       cs_high;
      logic       cs_low;
      logic       pulse;
      logic       shift;
      logic [1:0] mode;
      logic       wr;
   } cmd_dec_t;

   function automatic logic [NUM_LANES-1:0] lane_mask(input logic [1:0] mode);
      case (mode)
         2'd0:    lane_mask = 4'b0001;
         2'd1:    lane_mask = 4'b0011;
         default: lane_mask = 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/serpin_decode.sv
module serpin_decode
   import serpin_pkg::*;
#(
   parameter int CMD_W  = 16,
   parameter int OP_LSB = 8,
   parameter int WR_BIT = 13
) (
   input  logic [CMD_W-1:0] cmd_word,
   output cmd_dec_t         dec
);

   localparam int OP_MSB = OP_LSB + 3;

   if (OP_MSB >= CMD_W) begin : g_bad_op
      $error("opcode field exceeds command width");
   end
   if (WR_BIT >= CMD_W) begin : g_bad_wr
      $error("write bit exceeds command width");
   end

   logic [3:0] opcode;
   logic       unused_cmd_bits;

   assign opcode          = cmd_word[OP_MSB:OP_LSB];
   assign unused_cmd_bits = ^cmd_word;

   always_comb begin
      dec         = '0;
      dec.wr      = cmd_word[WR_BIT];
      case (opcode)
         OPC_CS_HIGH: dec.cs_high = 1'b1;
         OPC_CS_LOW:  dec.cs_low  = 1'b1;
         OPC_PULSE:   dec.pulse   = 1'b1;
         OPC_SH_X1: begin
            dec.shift = 1'b1;
            dec.mode  = 2'd0;
         end
         OPC_SH_X2: begin
            dec.shift = 1'b1;
            dec.mode  = 2'd1;
         end
         OPC_SH_X4: begin
            dec.shift = 1'b1;
            dec.mode  = 2'd2;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/serpin_phase_timer.sv
module serpin_phase_timer #(
   parameter int PHASE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               reload,
   input  logic [PHASE_W-1:0] len,
   output logic               expire
);

   if (PHASE_W < 1) begin : g_bad_w
      $error("phase counter needs at least one bit");
   end

   logic [PHASE_W-1:0] len_q;
   logic [PHASE_W-1:0] cnt_q;
   logic [PHASE_W-1:0] eff_len;

   assign eff_len = (len == '0) ? PHASE_W'(1) : len;
   assign expire  = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         cnt_q <= '0;
      end else if (start) begin
         len_q <= eff_len;
         cnt_q <= eff_len - PHASE_W'(1);
      end else if (reload) begin
         cnt_q <= len_q - PHASE_W'(1);
      end else if (!expire) begin
         cnt_q <= cnt_q - PHASE_W'(1);
      end
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q != '0) |-> (cnt_q < len_q));

endmodule

// File: rtl/serpin_lane_shifter.sv
module serpin_lane_shifter
   import serpin_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [1:0]           mode_in,
   input  logic [DATA_W-1:0]    data_in,
   input  logic                 advance,
   input  logic                 capture,
   input  logic [NUM_LANES-1:0] sdi,
   output logic [NUM_LANES-1:0] lane_out,
   output logic [DATA_W-1:0]    rx_next
);

   localparam int NUM_MODES = 3;

   if (DATA_W % NUM_LANES != 0 || DATA_W < NUM_LANES) begin : g_bad_data
      $error("data width must be a nonzero multiple of the lane count");
   end

   logic [DATA_W-1:0]    tx_q;
   logic [DATA_W-1:0]    rx_q;
   logic [1:0]           mode_q;

   logic [NUM_LANES-1:0] tx_lane  [NUM_MODES];
   logic [DATA_W-1:0]    tx_shift [NUM_MODES];
   logic [DATA_W-1:0]    rx_shift [NUM_MODES];
   logic [1:0]           mode_sel;

   for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
      localparam int W = 1 << g;
      assign tx_lane[g]  = NUM_LANES'(tx_q[DATA_W-1 -: W]);
      assign tx_shift[g] = {tx_q[DATA_W-W-1:0], {W{1'b0}}};
      assign rx_shift[g] = {rx_q[DATA_W-W-1:0], sdi[W-1:0]};
   end

   assign mode_sel = (mode_q == 2'd3) ? 2'd0 : mode_q;
   assign lane_out = tx_lane[mode_sel];
   assign rx_next  = rx_shift[mode_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         mode_q <= '0;
      end else if (load) begin
         tx_q   <= data_in;
         rx_q   <= '0;
         mode_q <= mode_in;
      end else begin
         if (advance) tx_q <= tx_shift[mode_sel];
         if (capture) rx_q <= rx_next;
      end
   end

   // R5
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != 2'd3);

endmodule

// File: rtl/serial_pin_sequencer.sv
module serial_pin_sequencer
   import serpin_pkg::*;
#(
   parameter int CMD_W   = 16,
   parameter int DATA_W  = 8,
   parameter int PHASE_W = 8,
   parameter int OP_LSB  = 8,
   parameter int WR_BIT  = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 man_en,
   input  logic                 path_sel,
   input  logic                 cmd_valid,
   input  logic [CMD_W-1:0]     cmd_word,
   input  logic                 vld_clear,
   input  logic [PHASE_W-1:0]   phase_len,
   input  logic [NUM_LANES-1:0] sdi,
   output logic                 busy,
   output logic                 csn,
   output logic                 sclk,
   output logic [NUM_LANES-1:0] sdo,
   output logic [NUM_LANES-1:0] sdo_oe,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdata_valid
);

   localparam int STEP_W = $clog2(DATA_W) + 1;

   if (DATA_W > OP_LSB) begin : g_bad_layout
      $error("shift data overlaps the opcode field");
   end

   seq_state_e          state_q;
   cmd_dec_t            dec;
   logic                accept;
   logic                expire;
   logic                timer_start;
   logic                timer_reload;
   logic                last_step;
   logic                in_shift;
   logic [STEP_W-1:0]   steps_q;
   logic                rd_q;
   logic [NUM_LANES-1:0] lane_out;
   logic [DATA_W-1:0]   rx_next;

   serpin_decode #(
      .CMD_W  (CMD_W),
      .OP_LSB (OP_LSB),
      .WR_BIT (WR_BIT)
   ) i_decode (
      .cmd_word (cmd_word),
      .dec      (dec)
   );

   assign busy      = (state_q != ST_IDLE);
   assign accept    = cmd_valid && man_en && path_sel && !busy;
   assign last_step = (steps_q == '0);
   assign in_shift  = (state_q == ST_SHIFT_LO) || (state_q == ST_SHIFT_HI);

   assign timer_start  = accept && (dec.pulse || dec.shift);
   assign timer_reload = expire && ((state_q == ST_PULSE_HI) ||
                                    (state_q == ST_SHIFT_LO) ||
                                    (state_q == ST_SHIFT_HI && !last_step));

   serpin_phase_timer #(
      .PHASE_W (PHASE_W)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (timer_start),
      .reload (timer_reload),
      .len    (phase_len),
      .expire (expire)
   );

   serpin_lane_shifter #(
      .DATA_W (DATA_W)
   ) i_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && dec.shift),
      .mode_in  (dec.mode),
      .data_in  (cmd_word[DATA_W-1:0]),
      .advance  (state_q == ST_SHIFT_HI && expire && !last_step),
      .capture  (state_q == ST_SHIFT_HI && expire),
      .sdi      (sdi),
      .lane_out (lane_out),
      .rx_next  (rx_next)
   );

   assign sdo = in_shift ? lane_out : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         csn         <= 1'b1;
         sclk        <= 1'b0;
         sdo_oe      <= '0;
         steps_q     <= '0;
         rd_q        <= 1'b0;
         rdata       <= '0;
         rdata_valid <= 1'b0;
      end else begin
         if (vld_clear) rdata_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (dec.cs_high) csn <= 1'b1;
                  if (dec.cs_low)  csn <= 1'b0;
                  if (dec.pulse) begin
                     state_q <= ST_PULSE_HI;
                     sclk    <= 1'b1;
                  end
                  if (dec.shift) begin
                     state_q <= ST_SHIFT_LO;
                     rd_q    <= !dec.wr;
                     sdo_oe  <= dec.wr ? lane_mask(dec.mode) : '0;
                     steps_q <= STEP_W'((DATA_W >> dec.mode) - 1);
                  end
               end
            end
            ST_PULSE_HI: begin
               if (expire) begin
                  state_q <= ST_PULSE_LO;
                  sclk    <= 1'b0;
               end
            end
            ST_PULSE_LO: begin
               if (expire) state_q <= ST_IDLE;
            end
            ST_SHIFT_LO: begin
               if (expire) begin
                  state_q <= ST_SHIFT_HI;
                  sclk    <= 1'b1;
               end
            end
            ST_SHIFT_HI: begin
               if (expire) begin
                  sclk <= 1'b0;
                  if (last_step) begin
                     state_q <= ST_IDLE;
                     sdo_oe  <= '0;
                     if (rd_q) begin
                        rdata       <= rx_next;
                        rdata_valid <= 1'b1;
                     end
                  end else begin
                     state_q <= ST_SHIFT_LO;
                     steps_q <= steps_q - STEP_W'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !(man_en && path_sel) && !busy) |=> (!busy && $stable(csn)));

   // R4
   idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R5
   csn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(csn));

   // R6
   idle_lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sdo_oe == '0));

   // R7
   valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdata_valid) |-> $fell(busy));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(csn));

endmodule

// File: tb/test_serial_pin_sequencer.sv
module test_serial_pin_sequencer;

   typedef struct packed {
      logic       csn;
      logic       sclk;
      logic [3:0] sdo;
      logic [3:0] oe;
      logic       busy;
      logic [3:0] sdi;
   } entry_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        man_en = 1'b0;
   logic        path_sel = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        vld_clear = 1'b0;
   logic [7:0]  phase_len = 8'd1;
   logic [3:0]  sdi = '0;
   logic        busy, csn, sclk, rdata_valid;
   logic [3:0]  sdo, sdo_oe;
   logic [7:0]  rdata;

   int     n_checks = 0;
   int     n_fail   = 0;
   logic   m_csn    = 1'b1;
   logic   m_rvalid = 1'b0;
   logic [7:0] m_rdata = '0;
   entry_t exp_q[$];

   logic   mon_en = 1'b0;
   logic   sclk_d = 1'b0;
   int     rise_all = 0;
   int     rise_low = 0;

   always #5 clk = ~clk;

   serial_pin_sequencer i_serial_pin_sequencer (
      .clk         (clk),
      .rst_n       (rst_n),
      .man_en      (man_en),
      .path_sel    (path_sel),
      .cmd_valid   (cmd_valid),
      .cmd_word    (cmd_word),
      .vld_clear   (vld_clear),
      .phase_len   (phase_len),
      .sdi         (sdi),
      .busy        (busy),
      .csn         (csn),
      .sclk        (sclk),
      .sdo         (sdo),
      .sdo_oe      (sdo_oe),
      .rdata       (rdata),
      .rdata_valid (rdata_valid)
   );

   always @(negedge clk) begin
      if (!mon_en) begin
         rise_all = 0;
         rise_low = 0;
      end else if (sclk && !sclk_d) begin
         rise_all++;
         if (!csn) rise_low++;
      end
      sclk_d = sclk;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, {21'd0, csn, sclk, sdo, sdo_oe, busy}, {21'd0, m_csn, 1'b0, 4'h0, 4'h0, 1'b0});
      chk(req, {23'd0, rdata_valid, rdata}, {23'd0, m_rvalid, m_rdata});
   endtask

   task automatic send(input string req, input logic [15:0] w, input int n,
                       input logic [7:0] rpat, input bit inj);
      entry_t e;
      int     nn;
      int     wd;
      bit     acc;
      bit     rd;
      logic [3:0] msk;
      nn  = (n == 0) ? 1 : n;
      acc = man_en && path_sel;
      rd  = 1'b0;
      exp_q.delete();
      phase_len = 8'(n);
      cmd_word  = w;
      cmd_valid = 1'b1;
      if (acc) begin
         if (w[11:8] == 4'h0) m_csn = 1'b1;
         else if (w[11:8] == 4'h1) m_csn = 1'b0;
         else if (w[11:8] == 4'h2) begin
            for (int h = 0; h < 2*nn; h++) begin
               e = '{csn: m_csn, sclk: (h < nn), sdo: 4'h0, oe: 4'h0, busy: 1'b1, sdi: 4'h0};
               exp_q.push_back(e);
            end
         end else if (w[11:8] >= 4'h8 && w[11:8] <= 4'hA) begin
            wd  = 1 << (w[11:8] - 4'h8);
            msk = 4'((1 << wd) - 1);
            rd  = !w[13];
            for (int k = 0; k < 8/wd; k++) begin
               for (int h = 0; h < 2*nn; h++) begin
                  e.csn  = m_csn;
                  e.sclk = (h >= nn);
                  e.sdo  = 4'(w[7:0] >> (8 - wd*(k+1))) & msk;
                  e.oe   = rd ? 4'h0 : msk;
                  e.busy = 1'b1;
                  e.sdi  = 4'(rpat >> (8 - wd*(k+1))) & msk;
                  exp_q.push_back(e);
               end
            end
         end
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < exp_q.size(); i++) begin
         e = exp_q[i];
         chk(req, {21'd0, csn, sclk, sdo, sdo_oe, busy},
                  {21'd0, e.csn, e.sclk, e.sdo, e.oe, e.busy});
         if (inj && i == 0) begin
            cmd_valid = 1'b1;
            cmd_word  = (m_csn ? 16'h2100 : 16'h2000);
         end
         if (inj && i == 1) cmd_valid = 1'b0;
         sdi = e.sdi;
         @(negedge clk);
      end
      if (acc && rd) begin
         m_rdata  = rpat;
         m_rvalid = 1'b1;
      end
      chk_idle(req);
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_idle("R1");

      // R2 gate closed: manual enable low, then path select low
      man_en = 1'b0; path_sel = 1'b1;
      send("R2", 16'h2100, 1, 8'h00, 1'b0);
      send("R2", 16'h28A5, 1, 8'h00, 1'b0);
      man_en = 1'b1; path_sel = 1'b0;
      send("R2", 16'h2100, 1, 8'h00, 1'b0);
      send("R2", 16'h2200, 1, 8'h00, 1'b0);
      path_sel = 1'b1;

      // R3 chip-select opcodes and an unused opcode
      send("R3", 16'h2100, 1, 8'h00, 1'b0);
      send("R3", 16'h2500, 1, 8'h00, 1'b0);
      send("R3", 16'h2000, 1, 8'h00, 1'b0);
      send("R3", 16'h2F00, 1, 8'h00, 1'b0);

      // R4 clock pulse, long phase and zero phase
      send("R4", 16'h2200, 3, 8'h00, 1'b0);
      send("R4", 16'h0200, 0, 8'h00, 1'b0);

      // R5 R6 write shifts in the three lane modes
      send("R5", 16'h28A5, 1, 8'h00, 1'b0);
      send("R6", 16'h293C, 2, 8'h00, 1'b0);
      send("R5", 16'h2A96, 1, 8'h00, 1'b0);

      // R7 read shifts
      send("R7", 16'h0800, 1, 8'h5A, 1'b0);
      send("R7", 16'h0A00, 2, 8'hC3, 1'b0);

      // R9 command during a running read shift
      send("R9", 16'h0900, 1, 8'h69, 1'b1);

      // R8 valid clear
      vld_clear = 1'b1;
      @(negedge clk);
      vld_clear = 1'b0;
      m_rvalid  = 1'b0;
      chk_idle("R8");

      // R10 slave reset sequence
      mon_en = 1'b1;
      send("R10", 16'h2100, 1, 8'h00, 1'b0);
      send("R10", 16'h28FF, 1, 8'h00, 1'b0);
      send("R10", 16'h2000, 1, 8'h00, 1'b0);
      for (int r = 0; r < 4; r++) send("R10", 16'h28FF, 1, 8'h00, 1'b0);
      chk("R10", 32'(rise_all), 32'd40);
      chk("R10", 32'(rise_low), 32'd8);
      chk("R10", {31'd0, csn}, 32'd1);
      mon_en = 1'b0;

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule